// File: doc/BRIEF.md
# Peripheral Idle and Standby Controller

This block is the power-management agent of a bus peripheral. A small register bank holds the configuration. It sets the slave idle policy, which decides how a system idle request is acknowledged, and the master standby policy, which decides when the peripheral tells the system that its master port may stop. The same bank holds a wakeup enable, an auto-idle switch that lets the interface clock be cut while nothing is happening, and a force-standby override.

A single `activity` input summarises whether the peripheral is busy. The block answers `idle_req` with `idle_ack` according to the slave policy. It drives `mstandby` from the master policy and the override. It raises `wakeup` when activity returns under an acknowledged idle, but only in the policy and enable combination that allows it. It drops `clk_en` while the bus is quiet and auto-idle is on.

Writing the soft-reset bit starts a fixed-length reset sequence. During the sequence the configuration returns to its defaults, further configuration writes are refused and the status register reports that reset is still running.

Top module: `pm_idle_ctrl`

## Requirements
- R1: After the reset input, the configuration word (index 0) reads 0x0000_1008: slave policy 1, master policy 1, every other field 0. The status word (index 1) reads 1, and the force word (index 2) reads 0.
- R2: In the configuration word, bit 0 is auto-idle, bit 1 is soft-reset, bit 2 is wakeup enable, bits 4:3 are the slave policy and bits 13:12 are the master policy. All other bits read 0 and writes to them are ignored. Indices 3 and up read 0.
- R3: With slave policy 0 (force), `idle_ack` rises in the cycle after `idle_req` is first sampled high, whatever `activity` is doing.
- R4: With slave policy 1 (never), `idle_ack` never rises.
- R5: With slave policy 2 or 3 (smart), `idle_ack` rises only after a clock edge at which `idle_req` is high and `activity` is low.
- R6: Once `idle_ack` is high, it stays high while `idle_req` stays high, even if `activity` returns. It falls in the cycle after `idle_req` is sampled low.
- R7: `wakeup` is high exactly when `idle_ack` and `activity` are high, the slave policy is 3 and the wakeup enable is 1. It is low in every other policy, including policy 2.
- R8: With the force bit clear, master policy 0 holds `mstandby` high, policy 1 (and the unused code 3) holds it low, and policy 2 drives it high exactly when `activity` is low.
- R9: While bit 0 of the force word is 1, `mstandby` is high whatever the master policy is.
- R10: A configuration write with bit 1 set starts a reset lasting RST_CYCLES clocks. While the reset runs, the status word reads 0, configuration bit 1 reads 1, and writes to indices 0 and 2 are ignored. Afterwards the status word reads 1, bit 1 reads 0, and the configuration and force words hold their reset values.
- R11: `clk_en` is low only when auto-idle is 1 and neither `activity` nor `reg_valid` is high in that same cycle.
- R12: A read (`reg_valid` high, `reg_write` low) returns its data on `reg_rdata` in the next cycle. In any cycle that follows no read, `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word index of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| idle_req | input | 1 | System idle request |
| idle_ack | output | 1 | Idle acknowledge |
| activity | input | 1 | Peripheral busy indication |
| wakeup | output | 1 | Wakeup request to the system |
| mstandby | output | 1 | Master standby indication |
| clk_en | output | 1 | Interface clock enable |

## Verification
The hardest case to reach is an acknowledged idle under the smart-with-wakeup policy, followed by a return of activity while the request is still held. To reach it, the stimulus first programs policy 3 and then lets `activity` fall so that the acknowledge is granted. It then raises `activity` again without touching `idle_req`. The same sequence is repeated with the wakeup enable cleared and with policy 2, so that the wakeup gating can be told apart from the sticky acknowledge. A second hard case is a configuration write during a soft reset. The bench issues one in the middle of the reset window and then confirms, through readback, that the write left nothing behind.

// File: rtl/pm_idle_pkg.sv
package pm_idle_pkg;

  typedef enum logic [1:0] {
    SI_FORCE      = 2'd0,
    SI_NEVER      = 2'd1,
    SI_SMART      = 2'd2,
    SI_SMART_WAKE = 2'd3
  } sidle_e;

  typedef enum logic [1:0] {
    MS_ALWAYS = 2'd0,
    MS_NEVER  = 2'd1,
    MS_SMART  = 2'd2,
    MS_UNUSED = 2'd3
  } mstby_e;

  typedef struct packed {
    mstby_e mstby;
    sidle_e sidle;
    logic   wake_en;
    logic   auto_idle;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{mstby: MS_NEVER, sidle: SI_NEVER,
                                  wake_en: 1'b0, auto_idle: 1'b0};

  localparam int IDX_CFG   = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_FORCE = 2;

  localparam int BIT_AUTO  = 0;
  localparam int BIT_SRST  = 1;
  localparam int BIT_WAKE  = 2;
  localparam int LSB_SIDLE = 3;
  localparam int LSB_MSTBY = 12;

  function automatic logic [31:0] pack_cfg(cfg_t c, logic busy);
    logic [31:0] w;
    w = '0;
    w[BIT_AUTO] = c.auto_idle;
    w[BIT_SRST] = busy;
    w[BIT_WAKE] = c.wake_en;
    w[LSB_SIDLE +: 2] = c.sidle;
    w[LSB_MSTBY +: 2] = c.mstby;
    return w;
  endfunction

  function automatic cfg_t unpack_cfg(logic [31:0] w);
    cfg_t c;
    c.auto_idle = w[BIT_AUTO];
    c.wake_en   = w[BIT_WAKE];
    c.sidle     = sidle_e'(w[LSB_SIDLE +: 2]);
    c.mstby     = mstby_e'(w[LSB_MSTBY +: 2]);
    return c;
  endfunction

endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_idle_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output cfg_t              cfg,
  output logic              force_stby,
  output logic              reset_done
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] srst_cnt;
  logic             busy;
  logic             hit_cfg, hit_stat, hit_force;
  logic             wr_cfg, wr_force, start_srst, rd_evt;
  logic [31:0]      rd_word;
  logic             unused_wdata_bits;

  assign busy       = (srst_cnt != '0);
  assign reset_done = !busy;
  assign hit_cfg    = (reg_addr == ADDR_W'(IDX_CFG));
  assign hit_stat   = (reg_addr == ADDR_W'(IDX_STAT));
  assign hit_force  = (reg_addr == ADDR_W'(IDX_FORCE));
  assign wr_cfg     = reg_valid && reg_write && hit_cfg && !busy;
  assign wr_force   = reg_valid && reg_write && hit_force && !busy;
  assign start_srst = wr_cfg && reg_wdata[BIT_SRST];
  assign rd_evt     = reg_valid && !reg_write;
  assign unused_wdata_bits = ^{reg_wdata[31:14], reg_wdata[11:5]};

  always_comb begin
    rd_word = '0;
    if (hit_cfg)        rd_word = pack_cfg(cfg, busy);
    else if (hit_stat)  rd_word[0] = reset_done;
    else if (hit_force) rd_word[0] = force_stby;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg        <= CFG_RESET;
      force_stby <= 1'b0;
      srst_cnt   <= '0;
      reg_rdata  <= '0;
    end else begin
      reg_rdata <= rd_evt ? rd_word : 32'd0;
      if (start_srst) begin
        cfg        <= CFG_RESET;
        force_stby <= 1'b0;
        srst_cnt   <= CNT_W'(RST_CYCLES);
      end else begin
        if (busy)     srst_cnt   <= srst_cnt - 1'b1;
        if (wr_cfg)   cfg        <= unpack_cfg(reg_wdata);
        if (wr_force) force_stby <= reg_wdata[0];
      end
    end
  end

  AST_SRST_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_srst |=> (!reset_done && cfg == CFG_RESET && !force_stby)); // R10
  AST_SRST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && srst_cnt == CNT_W'(1)) |=> reset_done); // R10
  AST_SRST_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_valid && reg_write) |=> ($stable(cfg) && $stable(force_stby))); // R10
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> (reg_rdata == 32'd0)); // R12

endmodule

// File: rtl/pm_idle_fsm.sv
module pm_idle_fsm
  import pm_idle_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   idle_req,
  input  logic   activity,
  input  sidle_e sidle,
  input  logic   wake_en,
  output logic   idle_ack,
  output logic   wakeup
);
  logic grant;
  logic ack_d;

  always_comb begin
    case (sidle)
      SI_FORCE: grant = 1'b1;
      SI_NEVER: grant = 1'b0;
      default:  grant = !activity;
    endcase
  end

  assign ack_d  = idle_req && (idle_ack || grant);
  assign wakeup = idle_ack && activity && wake_en && (sidle == SI_SMART_WAKE);

  always_ff @(posedge clk) begin
    if (!rst_n) idle_ack <= 1'b0;
    else        idle_ack <= ack_d;
  end

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ack && idle_req) |=> idle_ack); // R6
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |=> !idle_ack); // R6
  AST_NEVER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_ack && sidle == SI_NEVER) |=> !idle_ack); // R4
  AST_SMART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_ack && activity && (sidle == SI_SMART || sidle == SI_SMART_WAKE)) |=> !idle_ack); // R5
  AST_FORCE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && sidle == SI_FORCE) |=> idle_ack); // R3
  AST_WAKE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup |-> (idle_ack && wake_en && sidle == SI_SMART_WAKE)); // R7

endmodule

// File: rtl/pm_stby_gate.sv
module pm_stby_gate
  import pm_idle_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  mstby_e mstby,
  input  logic   force_stby,
  input  logic   auto_idle,
  input  logic   activity,
  input  logic   reg_valid,
  output logic   mstandby,
  output logic   clk_en
);
  logic policy_stby;

  always_comb begin
    case (mstby)
      MS_ALWAYS: policy_stby = 1'b1;
      MS_SMART:  policy_stby = !activity;
      default:   policy_stby = 1'b0;
    endcase
  end

  assign mstandby = force_stby || policy_stby;
  assign clk_en   = !auto_idle || activity || reg_valid;

  AST_FORCE_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    force_stby |-> mstandby); // R9
  AST_NEVER_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_stby && mstby == MS_NEVER) |-> !mstandby); // R8
  AST_CLK_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (activity || reg_valid) |-> clk_en); // R11

endmodule

// File: rtl/pm_idle_ctrl.sv
module pm_idle_ctrl
  import pm_idle_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              idle_req,
  output logic              idle_ack,
  input  logic              activity,
  output logic              wakeup,
  output logic              mstandby,
  output logic              clk_en
);
  cfg_t cfg;
  logic force_stby;
  logic reset_done;

  pm_cfg_regs #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg(cfg), .force_stby(force_stby), .reset_done(reset_done)
  );

  pm_idle_fsm u_idle (
    .clk(clk), .rst_n(rst_n),
    .idle_req(idle_req), .activity(activity),
    .sidle(cfg.sidle), .wake_en(cfg.wake_en),
    .idle_ack(idle_ack), .wakeup(wakeup)
  );

  pm_stby_gate u_stby (
    .clk(clk), .rst_n(rst_n),
    .mstby(cfg.mstby), .force_stby(force_stby), .auto_idle(cfg.auto_idle),
    .activity(activity), .reg_valid(reg_valid),
    .mstandby(mstandby), .clk_en(clk_en)
  );

  AST_WAKE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup |-> (idle_ack && activity)); // R7
  AST_DONE_NO_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_done) |-> (cfg == CFG_RESET)); // R10

endmodule

// File: tb/pm_idle_ctrl_tb.sv
module pm_idle_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 16;
  localparam int AW         = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_valid = 1'b0, reg_write = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          idle_req = 1'b0, activity = 1'b0;
  logic          idle_ack, wakeup, mstandby, clk_en;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_idle_ctrl #(.ADDR_W(AW), .RST_CYCLES(RST_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .idle_req(idle_req), .idle_ack(idle_ack), .activity(activity),
    .wakeup(wakeup), .mstandby(mstandby), .clk_en(clk_en)
  );

  // behavioural reference state
  int m_auto, m_wake, m_sidle, m_mstby, m_force, m_cnt, m_ack;
  logic [31:0] m_rdata;

  function automatic logic [31:0] model_read(int a);
    if (a == 0)
      return 32'((m_mstby << 12) + (m_sidle << 3) + (m_wake << 2) +
                 ((m_cnt > 0 ? 1 : 0) << 1) + m_auto);
    if (a == 1) return (m_cnt > 0) ? 32'd0 : 32'd1;
    if (a == 2) return 32'(m_force);
    return 32'd0;
  endfunction

  task automatic model_reset();
    m_auto = 0; m_wake = 0; m_sidle = 1; m_mstby = 1; m_force = 0; m_cnt = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset(); m_ack = 0; m_rdata = 0;
    end else begin
      logic [31:0] rv;
      int nack;
      rv = model_read(int'(reg_addr));
      nack = (idle_req && (m_ack == 1 || m_sidle == 0 || (m_sidle >= 2 && !activity))) ? 1 : 0;
      if (reg_valid && reg_write && m_cnt == 0) begin
        if (reg_addr == 0) begin
          if (reg_wdata[1]) begin model_reset(); m_cnt = RST_CYC; end
          else begin
            m_auto = reg_wdata[0]; m_wake = reg_wdata[2];
            m_sidle = int'(reg_wdata[4:3]); m_mstby = int'(reg_wdata[13:12]);
          end
        end else if (reg_addr == 2) m_force = reg_wdata[0];
      end else if (m_cnt > 0) m_cnt--;
      m_rdata = (reg_valid && !reg_write) ? rv : 32'd0;
      m_ack = nack;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("reg_rdata", reg_rdata, m_rdata);                                  // R12
      chk("idle_ack", 32'(idle_ack), 32'(m_ack));                            // R3 R4 R5 R6
      chk("wakeup", 32'(wakeup),
          32'(m_ack == 1 && activity && m_wake == 1 && m_sidle == 3));       // R7
      chk("mstandby", 32'(mstandby),
          32'(m_force == 1 || m_mstby == 0 || (m_mstby == 2 && !activity))); // R8 R9
      chk("clk_en", 32'(clk_en), 32'(m_auto == 0 || activity || reg_valid)); // R11
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_valid = 1; reg_write = 1; reg_addr = AW'(a); reg_wdata = d;
    tick();
    reg_valid = 0; reg_write = 0; reg_wdata = '0;
  endtask

  task automatic rd(int a);
    reg_valid = 1; reg_write = 0; reg_addr = AW'(a);
    tick();
    reg_valid = 0;
  endtask

  task automatic cfgw(int mstby, int sidle, int wake, int auto_i);
    wr(0, 32'((mstby << 12) + (sidle << 3) + (wake << 2) + auto_i));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    tick(3); rst_n = 1; tick();
    tag = "R1"; // reset values, explicit expected words
    rd(0); @(negedge clk); chk("cfg reset", reg_rdata, 32'h0000_1008);
    rd(1); @(negedge clk); chk("stat reset", reg_rdata, 32'd1);
    rd(2); @(negedge clk); chk("force reset", reg_rdata, 32'd0);
    tag = "R2"; // layout and reserved bits
    wr(0, 32'hFFFF_FFFD); rd(0); @(negedge clk); chk("cfg layout", reg_rdata, 32'h0000_301D);
    tick(2);
    rd(5); rd(3); rd(15);
    wr(7, 32'hFFFF_FFFF); rd(7);
    tag = "R11";
    cfgw(1, 1, 0, 1); tick(2);
    activity = 1; tick(); activity = 0; tick(2); rd(1); tick();
    tag = "R3";
    cfgw(1, 0, 0, 0);
    idle_req = 1; tick(); @(negedge clk); chk("force ack", 32'(idle_ack), 32'd1);
    activity = 1; tick(2); activity = 0; tick(); idle_req = 0; tick(2);
    activity = 1; idle_req = 1; tick(3); idle_req = 0; activity = 0; tick();
    tag = "R4";
    cfgw(1, 1, 0, 0);
    idle_req = 1; tick(4); activity = 1; tick(2); activity = 0; tick(2);
    @(negedge clk); chk("never ack", 32'(idle_ack), 32'd0);
    idle_req = 0; tick();
    tag = "R5";
    cfgw(1, 2, 0, 0);
    activity = 1; idle_req = 1; tick(4);
    @(negedge clk); chk("smart busy ack", 32'(idle_ack), 32'd0);
    activity = 0; tick(); @(negedge clk); chk("smart quiet ack", 32'(idle_ack), 32'd1);
    tag = "R6";
    activity = 1; tick(3); @(negedge clk); chk("sticky ack", 32'(idle_ack), 32'd1);
    idle_req = 0; tick(); @(negedge clk); chk("ack release", 32'(idle_ack), 32'd0);
    activity = 0; tick();
    tag = "R7";
    cfgw(1, 3, 1, 0);
    idle_req = 1; tick(2); activity = 1; tick(); #1;
    chk("wakeup mode3", 32'(wakeup), 32'd1);
    tick(2); activity = 0; tick(); idle_req = 0; tick();
    cfgw(1, 3, 0, 0);
    idle_req = 1; tick(2); activity = 1; tick(2); activity = 0; idle_req = 0; tick();
    cfgw(1, 2, 1, 0);
    idle_req = 1; tick(2); activity = 1; tick(); #1;
    chk("wakeup mode2", 32'(wakeup), 32'd0);
    activity = 0; idle_req = 0; tick(2);
    tag = "R8";
    for (int m = 0; m < 4; m++) begin
      cfgw(m, 1, 0, 0);
      tick(); activity = 1; tick(2); activity = 0; tick(2);
    end
    cfgw(2, 1, 0, 0); tick(); #1; chk("smart standby quiet", 32'(mstandby), 32'd1);
    tag = "R9";
    cfgw(1, 1, 0, 0); wr(2, 32'd1); rd(2);
    activity = 1; tick(); #1; chk("force standby", 32'(mstandby), 32'd1);
    activity = 0; tick(); wr(2, 32'd0); tick(2);
    tag = "R10";
    cfgw(2, 3, 1, 1); wr(2, 32'd1);
    wr(0, 32'h0000_0002);
    rd(1); @(negedge clk); chk("srst busy status", reg_rdata, 32'd0);
    rd(0); @(negedge clk); chk("srst cfg bit", reg_rdata, 32'h0000_100A);
    wr(0, 32'h0000_0005); wr(2, 32'd1);
    for (int i = 0; i < RST_CYC; i++) rd(1);
    rd(0); @(negedge clk); chk("srst after cfg", reg_rdata, 32'h0000_1008);
    rd(2); @(negedge clk); chk("srst after force", reg_rdata, 32'd0);
    tag = "R12";
    rd(0); tick(); @(negedge clk); chk("rdata cleared", reg_rdata, 32'd0);
    tick(3);
    finish_run();
  end
endmodule